// File: doc/BRIEF.md
# Inherent-Mode Register Instruction Executor

This block carries out a handful of single-byte, register-only instructions for an 8-bit accumulator machine. It owns the architectural registers: accumulator A, index X, index-high H, a 16-bit stack pointer and a six-bit condition-code register. A surrounding sequencer presents an opcode together with a one-cycle start strobe. The block then runs for the fixed number of bus cycles that belongs to that opcode, commits the result and pulses done.

Supported work covers several kinds of operation. There is a logical right shift of A or X, and a two's-complement negate of A or X. Unsigned multiply places its 16-bit product across X (high) and A (low). Nibble swap of A, a no-op, and pushes of A or H complete the set. A push drives a single-cycle byte write at the current stack address and then steps the stack pointer down. Any other opcode is refused with a one-cycle illegal pulse. The reset values of A, X, H and SP are parameters.

Top module: `acc_inh_exec`

## Requirements
- R1: During and right after reset, A, X, H and SP hold their parameter reset values. The condition codes read 6'b001000, using the layout bit5 V, bit4 H, bit3 I, bit2 N, bit1 Z, bit0 C. busy, done, illegal and wrEn are low.
- R2: A start accepted while idle raises busy for exactly N cycles and then raises done for one cycle with busy low. N is 1 for 0x44, 0x54, 0x40, 0x50, 0x62 and 0x9D, 2 for 0x87 and 0x8B, and 5 for 0x42.
- R3: A start strobe presented while busy is ignored: it neither alters the running operation nor produces a later completion.
- R4: 0x44 (A) and 0x54 (X) shift right by one with zero into bit 7. C takes the old bit 0, N is cleared, Z is set for a zero result and V equals N XOR C. H and I are unchanged.
- R5: 0x40 (A) and 0x50 (X) replace the register with 0x00 minus it. N is bit 7 of the result, Z is set for a zero result, V is set when the result is 0x80, and C is set when the result is nonzero. H and I are unchanged.
- R6: 0x42 writes the unsigned product X*A as X = high byte and A = low byte. It clears H and C and leaves V, I, N and Z unchanged.
- R7: 0x62 swaps the two nibbles of A and leaves the condition codes unchanged.
- R8: 0x9D changes no register and no condition code.
- R9: 0x87 and 0x8B raise wrEn for one cycle, together with done, with wrAddr equal to the old SP and wrData equal to A or H respectively. SP drops by one, wrapping from 0x0000 to 0xFFFF. wrEn is low at all other times.
- R10: Any other opcode raises illegal for exactly the cycle after acceptance. It does not raise busy or done, and it changes no register.
- R11: Registers and condition codes change only in the cycle done is high; they hold their values while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startStb | input | 1 | One-cycle request to execute `opcode` |
| opcode | input | 8 | Instruction byte sampled with `startStb` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse; results visible |
| illegal | output | 1 | One-cycle pulse for an unsupported opcode |
| wrEn | output | 1 | Stack byte write strobe |
| wrAddr | output | 16 | Stack write address |
| wrData | output | 8 | Stack write data |
| regA | output | 8 | Accumulator |
| regX | output | 8 | Index register (low) |
| regH | output | 8 | Index register (high) |
| regSp | output | 16 | Stack pointer |
| ccrOut | output | 6 | Condition codes {V,H,I,N,Z,C} |

## Verification
Several properties are checked on every cycle. Registers hold whenever no commit occurs, and done only ever follows busy. Illegal never overlaps busy, a write always coincides with done and a one-step SP decrement, and a shift always clears N while a multiply always clears H and C. Other behaviour only shows up in the scoreboard scenarios: the actual result values and flag rules for each opcode, the exact per-opcode cycle count, the stack-pointer wrap, and the refusal of a start issued in the middle of a multiply.

// File: rtl/acc_inh_pkg.sv
package acc_inh_pkg;
  localparam int DW    = 8;
  localparam int AW    = 16;
  localparam int CCR_W = 6;
  localparam int CYC_W = 3;

  localparam int CCR_C = 0;
  localparam int CCR_Z = 1;
  localparam int CCR_N = 2;
  localparam int CCR_I = 3;
  localparam int CCR_H = 4;
  localparam int CCR_V = 5;
  localparam logic [CCR_W-1:0] CCR_RESET = 6'b001000;

  localparam logic [CYC_W-1:0] CYC_ONE  = 3'd1;
  localparam logic [CYC_W-1:0] CYC_PUSH = 3'd2;
  localparam logic [CYC_W-1:0] CYC_MUL  = 3'd5;

  typedef enum logic [3:0] {
    OP_NOP, OP_LSRA, OP_LSRX, OP_NEGA, OP_NEGX,
    OP_MUL, OP_NSA, OP_PSHA, OP_PSHH
  } opSel_t;

  typedef struct packed {
    logic             legal;
    opSel_t           op;
    logic [CYC_W-1:0] cycles;
  } decode_t;

  typedef struct packed {
    logic   commit;
    opSel_t op;
  } dpCtrl_t;

  function automatic decode_t decodeOp(input logic [DW-1:0] code);
    decode_t d;
    d.legal  = 1'b1;
    d.op     = OP_NOP;
    d.cycles = CYC_ONE;
    case (code)
      8'h44: d.op = OP_LSRA;
      8'h54: d.op = OP_LSRX;
      8'h40: d.op = OP_NEGA;
      8'h50: d.op = OP_NEGX;
      8'h62: d.op = OP_NSA;
      8'h9D: d.op = OP_NOP;
      8'h42: begin d.op = OP_MUL;  d.cycles = CYC_MUL;  end
      8'h87: begin d.op = OP_PSHA; d.cycles = CYC_PUSH; end
      8'h8B: begin d.op = OP_PSHH; d.cycles = CYC_PUSH; end
      default: d.legal = 1'b0;
    endcase
    return d;
  endfunction

  // Flags after a one-bit logical right shift of v
  function automatic logic [CCR_W-1:0] shiftFlags(input logic [DW-1:0] v,
                                                  input logic [CCR_W-1:0] c);
    logic [CCR_W-1:0] f;
    f = c;
    f[CCR_C] = v[0];
    f[CCR_N] = 1'b0;
    f[CCR_Z] = (v[DW-1:1] == '0);
    f[CCR_V] = v[0];
    return f;
  endfunction

  // Flags for a negate whose result is r
  function automatic logic [CCR_W-1:0] negFlags(input logic [DW-1:0] r,
                                                input logic [CCR_W-1:0] c);
    logic [CCR_W-1:0] f;
    f = c;
    f[CCR_N] = r[DW-1];
    f[CCR_Z] = (r == '0);
    f[CCR_V] = (r == {1'b1, {(DW-1){1'b0}}});
    f[CCR_C] = (r != '0);
    return f;
  endfunction
endpackage

// File: rtl/acc_inh_ctrl.sv
module acc_inh_ctrl
  import acc_inh_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          startStb,
  input  logic [DW-1:0] opcode,
  output logic          busy,
  output logic          done,
  output logic          illegal,
  output dpCtrl_t       dpCtl
);
  logic [CYC_W-1:0] cnt;
  opSel_t           curOp;
  decode_t          dec;
  logic             lastCycle;

  assign dec       = decodeOp(opcode);
  assign lastCycle = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
      cnt     <= '0;
      curOp   <= OP_NOP;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      if (!busy) begin
        if (startStb) begin
          if (dec.legal) begin
            busy  <= 1'b1;
            cnt   <= dec.cycles - 1'b1;
            curOp <= dec.op;
          end else begin
            illegal <= 1'b1;
          end
        end
      end else if (lastCycle) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign dpCtl.commit = lastCycle;
  assign dpCtl.op     = curOp;

  // R2: done only on the cycle right after the busy window closes
  a_r2_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R10: an illegal pulse comes from the idle state and never starts work
  a_r10_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && !done && !$past(busy)));

  // R3: while busy and not finishing, the operation is kept
  a_r3_op_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !lastCycle) |=> (busy && $stable(curOp)));
endmodule

// File: rtl/acc_inh_dp.sv
module acc_inh_dp
  import acc_inh_pkg::*;
#(
  parameter logic [DW-1:0] RESET_A  = 8'h00,
  parameter logic [DW-1:0] RESET_X  = 8'h00,
  parameter logic [DW-1:0] RESET_H  = 8'h00,
  parameter logic [AW-1:0] RESET_SP = 16'h00FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpCtrl_t          dpCtl,
  output logic [DW-1:0]    regA,
  output logic [DW-1:0]    regX,
  output logic [DW-1:0]    regH,
  output logic [AW-1:0]    regSp,
  output logic [CCR_W-1:0] ccr,
  output logic             wrEn,
  output logic [AW-1:0]    wrAddr,
  output logic [DW-1:0]    wrData
);
  logic [2*DW-1:0] prod;
  logic [DW-1:0]   negA;
  logic [DW-1:0]   negX;

  assign prod = (2*DW)'(regX) * (2*DW)'(regA);
  assign negA = '0 - regA;
  assign negX = '0 - regX;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regA   <= RESET_A;
      regX   <= RESET_X;
      regH   <= RESET_H;
      regSp  <= RESET_SP;
      ccr    <= CCR_RESET;
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrEn <= 1'b0;
      if (dpCtl.commit) begin
        case (dpCtl.op)
          OP_LSRA: begin
            regA <= regA >> 1;
            ccr  <= shiftFlags(regA, ccr);
          end
          OP_LSRX: begin
            regX <= regX >> 1;
            ccr  <= shiftFlags(regX, ccr);
          end
          OP_NEGA: begin
            regA <= negA;
            ccr  <= negFlags(negA, ccr);
          end
          OP_NEGX: begin
            regX <= negX;
            ccr  <= negFlags(negX, ccr);
          end
          OP_MUL: begin
            regX       <= prod[2*DW-1:DW];
            regA       <= prod[DW-1:0];
            ccr[CCR_H] <= 1'b0;
            ccr[CCR_C] <= 1'b0;
          end
          OP_NSA: regA <= {regA[DW/2-1:0], regA[DW-1:DW/2]};
          OP_PSHA: begin
            wrEn   <= 1'b1;
            wrAddr <= regSp;
            wrData <= regA;
            regSp  <= regSp - 1'b1;
          end
          OP_PSHH: begin
            wrEn   <= 1'b1;
            wrAddr <= regSp;
            wrData <= regH;
            regSp  <= regSp - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R11: without a commit strobe no architectural state moves
  a_r11_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dpCtl.commit |=> $stable({regA, regX, regH, regSp, ccr}));

  // R9: every stack write steps SP down by exactly one
  a_r9_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> (regSp == $past(regSp) - 16'd1));

  // R4: a shift always leaves N clear
  a_r4_shift_n_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dpCtl.commit && (dpCtl.op == OP_LSRA || dpCtl.op == OP_LSRX)) |=> !ccr[CCR_N]);

  // R6: multiply always clears H and C
  a_r6_mul_hc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dpCtl.commit && dpCtl.op == OP_MUL) |=> (!ccr[CCR_H] && !ccr[CCR_C]));
endmodule

// File: rtl/acc_inh_exec.sv
module acc_inh_exec
  import acc_inh_pkg::*;
#(
  parameter logic [7:0]  RESET_A  = 8'h00,
  parameter logic [7:0]  RESET_X  = 8'h00,
  parameter logic [7:0]  RESET_H  = 8'h00,
  parameter logic [15:0] RESET_SP = 16'h00FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startStb,
  input  logic [7:0]  opcode,
  output logic        busy,
  output logic        done,
  output logic        illegal,
  output logic        wrEn,
  output logic [15:0] wrAddr,
  output logic [7:0]  wrData,
  output logic [7:0]  regA,
  output logic [7:0]  regX,
  output logic [7:0]  regH,
  output logic [15:0] regSp,
  output logic [5:0]  ccrOut
);
  dpCtrl_t dpCtl;

  acc_inh_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .startStb (startStb),
    .opcode   (opcode),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .dpCtl    (dpCtl)
  );

  acc_inh_dp #(
    .RESET_A  (RESET_A),
    .RESET_X  (RESET_X),
    .RESET_H  (RESET_H),
    .RESET_SP (RESET_SP)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .dpCtl  (dpCtl),
    .regA   (regA),
    .regX   (regX),
    .regH   (regH),
    .regSp  (regSp),
    .ccr    (ccrOut),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData)
  );

  // R9: a stack write is only ever seen with a completion
  a_r9_write_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> done);
endmodule

// File: tb/acc_inh_exec_tb.sv
module acc_inh_exec_tb;
  localparam logic [7:0]  INIT_A  = 8'h08;
  localparam logic [7:0]  INIT_X  = 8'h3C;
  localparam logic [7:0]  INIT_H  = 8'h9A;
  localparam logic [15:0] INIT_SP = 16'h0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startStb = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        busy, done, illegal, wrEn;
  logic [15:0] wrAddr, regSp;
  logic [7:0]  wrData, regA, regX, regH;
  logic [5:0]  ccrOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  acc_inh_exec #(
    .RESET_A(INIT_A), .RESET_X(INIT_X), .RESET_H(INIT_H), .RESET_SP(INIT_SP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .startStb(startStb), .opcode(opcode),
    .busy(busy), .done(done), .illegal(illegal), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .regA(regA), .regX(regX),
    .regH(regH), .regSp(regSp), .ccrOut(ccrOut)
  );

  typedef struct {
    int          cycAt;
    bit          ill;
    bit [7:0]    a, x, h;
    bit [15:0]   sp;
    bit [5:0]    cc;
    bit          wr;
    bit [15:0]   wa;
    bit [7:0]    wd;
    string       tag;
  } expItem_t;

  expItem_t sbq[$];

  // model state, advanced only when an item is retired
  bit [7:0]  mA = INIT_A, mX = INIT_X, mH = INIT_H;
  bit [15:0] mSp = INIT_SP;
  bit [5:0]  mCc = 6'b001000;
  // projected state the driver builds expectations from
  bit [7:0]  pA = INIT_A, pX = INIT_X, pH = INIT_H;
  bit [15:0] pSp = INIT_SP;
  bit [5:0]  pCc = 6'b001000;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // flag bits: 5 V, 4 H, 3 I, 2 N, 1 Z, 0 C
  function automatic expItem_t model(input bit [7:0] op);
    expItem_t e;
    int n;
    bit [15:0] p;
    bit cOut;
    e.ill = 1'b0; e.wr = 1'b0; e.wa = 16'h0; e.wd = 8'h0;
    e.a = pA; e.x = pX; e.h = pH; e.sp = pSp; e.cc = pCc;
    n = 1;
    case (op)
      8'h44, 8'h54: begin
        e.tag = "R4";
        if (op == 8'h44) begin cOut = e.a[0]; e.a = e.a >> 1; p = {8'h0, e.a}; end
        else begin cOut = e.x[0]; e.x = e.x >> 1; p = {8'h0, e.x}; end
        e.cc[0] = cOut; e.cc[2] = 1'b0; e.cc[1] = (p == 16'h0); e.cc[5] = cOut;
      end
      8'h40, 8'h50: begin
        e.tag = "R5";
        if (op == 8'h40) begin e.a = 8'h00 - e.a; p = {8'h0, e.a}; end
        else begin e.x = 8'h00 - e.x; p = {8'h0, e.x}; end
        e.cc[2] = p[7]; e.cc[1] = (p == 16'h0);
        e.cc[5] = (p == 16'h0080); e.cc[0] = (p != 16'h0);
      end
      8'h42: begin
        e.tag = "R6"; n = 5;
        p = 16'(e.x) * 16'(e.a);
        e.x = p[15:8]; e.a = p[7:0]; e.cc[4] = 1'b0; e.cc[0] = 1'b0;
      end
      8'h62: begin e.tag = "R7"; e.a = {e.a[3:0], e.a[7:4]}; end
      8'h9D: e.tag = "R8";
      8'h87, 8'h8B: begin
        e.tag = "R9"; n = 2; e.wr = 1'b1; e.wa = e.sp;
        e.wd = (op == 8'h87) ? e.a : e.h; e.sp = e.sp - 16'd1;
      end
      default: begin e.tag = "R10"; e.ill = 1'b1; n = 0; end
    endcase
    e.cycAt = cyc + 1 + n;
    return e;
  endfunction

  task automatic issue(input bit [7:0] op);
    expItem_t e;
    do @(negedge clk); while (sbq.size() != 0 || busy);
    e = model(op);
    pA = e.a; pX = e.x; pH = e.h; pSp = e.sp; pCc = e.cc;
    sbq.push_back(e);
    opcode = op; startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
  endtask

  // monitor: retire expected items as completions appear
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done || illegal) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R3", "unexpected completion", cyc, 0);
        end else begin
          expItem_t e;
          e = sbq.pop_front();
          check(cyc == e.cycAt, "R2", {e.tag, " completion cycle"}, cyc, e.cycAt);
          check(illegal == e.ill, "R10", {e.tag, " illegal flag"}, illegal, e.ill);
          check(done == !e.ill, "R10", {e.tag, " done flag"}, done, !e.ill);
          check(regA == e.a, e.tag, "A", regA, e.a);
          check(regX == e.x, e.tag, "X", regX, e.x);
          check(regH == e.h, e.tag, "H", regH, e.h);
          check(regSp == e.sp, e.tag, "SP", regSp, e.sp);
          check(ccrOut == e.cc, e.tag, "flags", ccrOut, e.cc);
          check(wrEn == e.wr, "R9", {e.tag, " wrEn"}, wrEn, e.wr);
          if (e.wr) begin
            check(wrAddr == e.wa, "R9", "wrAddr", wrAddr, e.wa);
            check(wrData == e.wd, "R9", "wrData", wrData, e.wd);
          end
          mA = e.a; mX = e.x; mH = e.h; mSp = e.sp; mCc = e.cc;
        end
      end else begin
        check(!wrEn, "R9", "wrEn outside done", wrEn, 0);
        if (busy) begin
          check({regA, regX, regH, regSp, ccrOut} == {mA, mX, mH, mSp, mCc},
                "R11", "state moved while busy",
                {regA, regX, regH, regSp, ccrOut}, {mA, mX, mH, mSp, mCc});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values held during reset
    check(regA == INIT_A && regX == INIT_X && regH == INIT_H, "R1", "A/X/H in reset",
          {regA, regX, regH}, {INIT_A, INIT_X, INIT_H});
    check(regSp == INIT_SP, "R1", "SP in reset", regSp, INIT_SP);
    check(ccrOut == 6'b001000, "R1", "flags in reset", ccrOut, 6'b001000);
    check(!busy && !done && !illegal && !wrEn, "R1", "status in reset",
          {busy, done, illegal, wrEn}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !illegal && !wrEn, "R1", "status after reset",
          {busy, done, illegal, wrEn}, 0);

    issue(8'h9D);                 // R8 no-op
    issue(8'h62);                 // R7 swap: 0x08 -> 0x80
    issue(8'h40);                 // R5 negate 0x80 -> 0x80, V set
    issue(8'h87);                 // R9 push A at 0x0001
    issue(8'h8B);                 // R9 push H at 0x0000, SP wraps
    issue(8'h44);                 // R4 shift A
    issue(8'h54);                 // R4 shift X
    issue(8'h42);                 // R6 multiply, then a start while busy
    repeat (2) @(negedge clk);
    opcode = 8'h40; startStb = 1'b1;   // R3: must be ignored
    @(negedge clk);
    startStb = 1'b0;
    issue(8'h50);                 // R5 negate X
    issue(8'h12);                 // R10 unknown opcode
    issue(8'hFF);                 // R10 unknown opcode
    issue(8'h87);                 // R9 second push after wrap
    for (int i = 0; i < 8; i++) issue(8'h54);   // R4 shift X to zero, Z set
    issue(8'h50);                 // R5 negate zero: C and V clear
    issue(8'h42);                 // R6 multiply by zero
    issue(8'h62);                 // R7 swap zero
    issue(8'h40);                 // R5 negate A
    do @(negedge clk); while (sbq.size() != 0 || busy);
    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R3", "pending items", sbq.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule